// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

The block keeps a window of trace history on chip. Packed trace words arrive on a valid-qualified input and are written into a circular RAM at a write pointer that advances by itself. A trigger input starts a post-trigger countdown. When the countdown runs out, acquisition ends. Software can then stop capture, set the read pointer and pull the stored words out one by one through a data register that advances on each read.

Software reaches the block through a flat register port: a 4-bit register select, read and write strobes, a 32-bit write bus and a read bus that decodes from the select with no delay. There are nine registers. The status register reports four flags: wrap, trigger seen, acquisition complete and formatter empty. Each trace word passes through one staging register before it reaches the RAM. The formatter-empty flag shows whether that stage still holds data.

Top module: `trace_capture_buf`

## Requirements
- R1: Register select values are 0 identification (reads ID_VALUE), 1 depth (reads DEPTH), 2 word width (reads WORD_W), 3 status, 4 data, 5 read pointer, 6 write pointer, 7 trigger count, 8 control. After reset the status reads 8, and both pointers, the count and the control read 0.
- R2: While capture is active, each cycle with `trc_valid` high stores `trc_word` at the write pointer, and the pointer then advances modulo DEPTH (a power of two). While control bit 0 is clear, input words are not stored.
- R3: Status bit 0 (wrap) sets when a word is stored at entry DEPTH-1. It stays set, including across pointer writes, until capture is restarted. A restart is a control write with bit 0 = 1 while bit 0 was 0, and it also clears status bits 1 and 2.
- R4: Status bit 1 (triggered) sets when `trc_trigger` is high while capture is active. A trigger is ignored while capture is disabled.
- R5: Each word stored after the trigger cycle decrements the trigger count while it is nonzero. Once the trigger has been seen and the count is 0, no further word is stored, status bit 2 (acquisition complete) sets and `capture_on` drops, even with control bit 0 still set.
- R6: Status bit 3 (formatter empty) is high whenever the staging register holds no word. It is always high while status bit 2 is set.
- R7: A read of register 4 with `reg_rd` high returns the RAM word at the read pointer. The read pointer then advances by one modulo DEPTH, so successive reads return successive entries.
- R8: Writes to registers 5, 6 and 7 load the read pointer, the write pointer (low log2(DEPTH) bits) and the trigger count. After a write of 0 to register 6, the next stored word lands in entry 0.
- R9: Control bit 1 selects demultiplexed port mode and appears on `demux_mode`. The control register reads back bits 1:0.
- R10: Reads of register select values 9 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_valid | input | 1 | Trace word present this cycle |
| trc_word | input | WORD_W | Packed trace word |
| trc_trigger | input | 1 | Trigger event |
| reg_sel | input | 4 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances read pointer on data reads) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded from reg_sel |
| capture_on | output | 1 | Words are currently being accepted |
| demux_mode | output | 1 | Demultiplexed port mode selected |

## Verification
A wrong pointer shows up at the first readback. Every data read after the fault returns a word that differs from the expected stored order, and the read-pointer register disagrees right after a block read. A countdown that is off by one moves the write pointer by one, and the status flags show it within a cycle of the input going idle. A wrap flag that clears too early, or a trigger latched while disabled, is visible on the next status read. The randomized rounds vary the trigger position, the count and the valid density, so that both the wrapped and the unwrapped readback paths are exercised.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [3:0] {
        RA_ID     = 4'd0,
        RA_DEPTH  = 4'd1,
        RA_WIDTH  = 4'd2,
        RA_STATUS = 4'd3,
        RA_DATA   = 4'd4,
        RA_RPTR   = 4'd5,
        RA_WPTR   = 4'd6,
        RA_TCNT   = 4'd7,
        RA_CTRL   = 4'd8
    } reg_addr_e;

    // bit 3 .. bit 0
    typedef struct packed {
        logic fmt_empty;
        logic acq_done;
        logic trig_seen;
        logic wrapped;
    } cap_status_t;

    typedef struct packed {
        logic demux;
        logic enable;
    } cap_ctrl_t;

    function automatic logic sel_is(input logic [3:0] sel, input reg_addr_e a);
        return sel == 4'(a);
    endfunction

endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_acq.sv
module tcb_acq
    import tcb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_trig,
    input  logic              wp_wr,
    input  logic [AW-1:0]     wp_val,
    input  logic              cnt_wr,
    input  logic [31:0]       cnt_val,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [AW-1:0]     wptr,
    output logic [31:0]       cnt,
    output cap_status_t       status,
    output logic              active
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic              stg_vld;
    logic [WORD_W-1:0] stg_word;
    logic              full_q, trig_q, done_q;
    logic              stopping, accept;

    assign stopping = trig_q && (cnt == 32'd0);
    assign active   = en && !done_q && !stopping;
    assign accept   = active && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld  <= 1'b0;
            stg_word <= '0;
            wptr     <= '0;
            full_q   <= 1'b0;
            trig_q   <= 1'b0;
            done_q   <= 1'b0;
            cnt      <= '0;
        end else begin
            stg_vld <= accept;
            if (accept) stg_word <= in_word;

            if (wp_wr)        wptr <= wp_val;
            else if (stg_vld) wptr <= wptr + 1'b1;

            if (restart)                                   full_q <= 1'b0;
            else if (stg_vld && !wp_wr && wptr == LAST)    full_q <= 1'b1;

            if (restart)               trig_q <= 1'b0;
            else if (active && in_trig) trig_q <= 1'b1;

            if (restart)              done_q <= 1'b0;
            else if (en && stopping)  done_q <= 1'b1;

            if (cnt_wr)                                   cnt <= cnt_val;
            else if (accept && trig_q && cnt != 32'd0)    cnt <= cnt - 32'd1;
        end
    end

    assign ram_we    = stg_vld;
    assign ram_waddr = wptr;
    assign ram_wdata = stg_word;

    assign status.fmt_empty = !stg_vld;
    assign status.acq_done  = done_q;
    assign status.trig_seen = trig_q;
    assign status.wrapped   = full_q;

    // R3: wrap flag only drops on a restart
    a_r3_wrap_sticky: assert property (@(posedge clk) disable iff (rst)
        (full_q && !restart) |=> full_q);

    // R4: trigger is latched only while capture was enabled
    a_r4_trig_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_q) |-> $past(en));

    // R5: no pointer movement once acquisition has completed
    a_r5_halt_after_done: assert property (@(posedge clk) disable iff (rst)
        (done_q && !wp_wr && !restart) |=> (wptr == $past(wptr)));

    // R6: staging register is drained whenever acquisition is complete
    a_r6_empty_when_done: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !stg_vld);

    // R2: a staged word moves the write pointer by exactly one
    a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst)
        (stg_vld && !wp_wr) |=> (wptr == $past(wptr) + 1'b1));
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
    import tcb_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h7C0B_0011,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  cap_status_t       status,
    input  logic [AW-1:0]     wptr,
    input  logic [31:0]       cnt,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic [AW-1:0]     rptr,
    output cap_ctrl_t         ctrl,
    output logic              restart,
    output logic              wp_wr,
    output logic [AW-1:0]     wp_val,
    output logic              cnt_wr,
    output logic [31:0]       cnt_val
);
    logic wr_ctrl, wr_rptr, data_pop;

    assign wr_ctrl  = reg_wr && sel_is(reg_sel, RA_CTRL);
    assign wr_rptr  = reg_wr && sel_is(reg_sel, RA_RPTR);
    assign wp_wr    = reg_wr && sel_is(reg_sel, RA_WPTR);
    assign cnt_wr   = reg_wr && sel_is(reg_sel, RA_TCNT);
    assign wp_val   = reg_wdata[AW-1:0];
    assign cnt_val  = reg_wdata;
    assign data_pop = reg_rd && sel_is(reg_sel, RA_DATA);
    assign restart  = wr_ctrl && reg_wdata[0] && !ctrl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            rptr <= '0;
        end else begin
            if (wr_ctrl) ctrl <= cap_ctrl_t'(reg_wdata[1:0]);
            if (wr_rptr)       rptr <= reg_wdata[AW-1:0];
            else if (data_pop) rptr <= rptr + 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            RA_ID:     reg_rdata = ID_VALUE;
            RA_DEPTH:  reg_rdata = 32'(DEPTH);
            RA_WIDTH:  reg_rdata = 32'(WORD_W);
            RA_STATUS: reg_rdata = 32'(status);
            RA_DATA:   reg_rdata = 32'(ram_rdata);
            RA_RPTR:   reg_rdata = 32'(rptr);
            RA_WPTR:   reg_rdata = 32'(wptr);
            RA_TCNT:   reg_rdata = cnt;
            RA_CTRL:   reg_rdata = 32'(ctrl);
            default:   reg_rdata = '0;
        endcase
    end

    // R7: a data read advances the read pointer by one
    a_r7_rptr_step: assert property (@(posedge clk) disable iff (rst)
        (data_pop && !wr_rptr) |=> (rptr == $past(rptr) + 1'b1));

    // R10: unused select values read as zero
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_sel > 4'd8) |-> (reg_rdata == 32'd0));
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h7C0B_0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trc_valid,
    input  logic [WORD_W-1:0] trc_word,
    input  logic              trc_trigger,
    input  logic [3:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              capture_on,
    output logic              demux_mode
);
    localparam int AW = $clog2(DEPTH);

    cap_status_t       status;
    cap_ctrl_t         ctrl;
    logic              restart, wp_wr, cnt_wr, ram_we;
    logic [AW-1:0]     wp_val, wptr, rptr, ram_waddr;
    logic [31:0]       cnt, cnt_val;
    logic [WORD_W-1:0] ram_wdata, ram_rdata;

    tcb_regs #(.DEPTH(DEPTH), .WORD_W(WORD_W), .ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst(rst),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .status(status), .wptr(wptr), .cnt(cnt), .ram_rdata(ram_rdata),
        .rptr(rptr), .ctrl(ctrl), .restart(restart),
        .wp_wr(wp_wr), .wp_val(wp_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val)
    );

    tcb_acq #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_acq (
        .clk(clk), .rst(rst),
        .en(ctrl.enable), .restart(restart),
        .in_valid(trc_valid), .in_word(trc_word), .in_trig(trc_trigger),
        .wp_wr(wp_wr), .wp_val(wp_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .wptr(wptr), .cnt(cnt), .status(status), .active(capture_on)
    );

    tcb_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(rptr), .rdata(ram_rdata)
    );

    assign demux_mode = ctrl.demux;
endmodule

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trc_valid = 1'b0, trc_trigger = 1'b0;
    logic [31:0] trc_word = '0;
    logic [3:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        capture_on, demux_mode;

    int n_tests = 0, n_fail = 0;

    // bench model state
    bit          m_en, m_done, m_trig, m_full;
    int          m_cnt, m_wp;
    logic [31:0] m_mem [D];

    always #2 clk = ~clk;

    trace_capture_buf u_dut (
        .clk(clk), .rst(rst), .trc_valid(trc_valid), .trc_word(trc_word),
        .trc_trigger(trc_trigger), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .capture_on(capture_on), .demux_mode(demux_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_sel = a; reg_rd = 1'b1; reg_wr = 1'b0;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_sel = a; reg_wdata = v; reg_wr = 1'b1; reg_rd = 1'b0;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        case (a)
            4'd6: m_wp = int'(v) % D;
            4'd7: m_cnt = int'(v);
            4'd8: begin
                if (v[0] && !m_en) begin m_full = 0; m_trig = 0; m_done = 0; end
                m_en = v[0];
            end
            default: ;
        endcase
    endtask

    task automatic tick(input bit v, input logic [31:0] w, input bit t);
        bit stop_c, act_c, acc_c;
        @(negedge clk);
        trc_valid = v; trc_word = w; trc_trigger = t;
        stop_c = m_trig && (m_cnt == 0);
        act_c  = m_en && !m_done && !stop_c;
        acc_c  = act_c && v;
        if (m_en && stop_c) m_done = 1;
        if (acc_c) begin
            m_mem[m_wp] = w;
            if (m_wp == D - 1) m_full = 1;
            m_wp = (m_wp + 1) % D;
            if (m_trig && m_cnt != 0) m_cnt--;
        end
        if (act_c && t) m_trig = 1;
        @(posedge clk); #1;
        trc_valid = 1'b0; trc_trigger = 1'b0;
    endtask

    function automatic logic [31:0] exp_status();
        bit d;
        d = m_done || (m_en && m_trig && m_cnt == 0);
        return {28'd0, 1'b1, d, m_trig, m_full};
    endfunction

    task automatic restart_cap(input int cnt, input bit demux);
        wr_reg(4'd7, cnt);
        wr_reg(4'd6, 0);
        wr_reg(4'd8, 0);
        wr_reg(4'd8, {30'd0, demux, 1'b1});
    endtask

    task automatic readback_all(input string tag);
        logic [31:0] v;
        int start, n;
        if (m_full) begin start = m_wp; n = D; end
        else begin start = 0; n = m_wp; end
        wr_reg(4'd5, start);
        for (int i = 0; i < n; i++) begin
            rd_reg(4'd4, v);
            chk({tag, " R7 data"}, v, m_mem[(start + i) % D]);
        end
        rd_reg(4'd5, v);
        chk({tag, " R7 rptr after reads"}, v, 32'((start + n) % D));
    endtask

    initial begin
        #600000;
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        m_en = 0; m_done = 0; m_trig = 0; m_full = 0; m_cnt = 0; m_wp = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state and constants
        rd_reg(4'd0, v); chk("R1 id", v, 32'h7C0B_0011);
        rd_reg(4'd1, v); chk("R1 depth", v, 32'd16);
        rd_reg(4'd2, v); chk("R1 width", v, 32'd32);
        rd_reg(4'd3, v); chk("R1 status", v, 32'd8);
        rd_reg(4'd5, v); chk("R1 rptr", v, 32'd0);
        rd_reg(4'd6, v); chk("R1 wptr", v, 32'd0);
        rd_reg(4'd7, v); chk("R1 count", v, 32'd0);
        rd_reg(4'd8, v); chk("R1 ctrl", v, 32'd0);

        // R10 unused selects
        for (int a = 9; a < 16; a++) begin
            rd_reg(4'(a), v); chk("R10 unused", v, 32'd0);
        end

        // R2, R4: disabled capture ignores words and trigger
        for (int i = 0; i < 5; i++) tick(1, $urandom, i == 2);
        repeat (2) tick(0, 0, 0);
        rd_reg(4'd6, v); chk("R2 wptr while disabled", v, 32'd0);
        rd_reg(4'd3, v); chk("R4 trigger ignored", v, 32'd8);
        chk("R5 capture_on off", {31'd0, capture_on}, 32'd0);

        // R9 demux mode
        wr_reg(4'd8, 32'd2);
        chk("R9 demux out", {31'd0, demux_mode}, 32'd1);
        rd_reg(4'd8, v); chk("R9 ctrl readback", v, 32'd2);
        wr_reg(4'd8, 32'd0);

        // R5 corner: count 0, trigger on first word
        restart_cap(0, 0);
        chk("R5 capture_on on", {31'd0, capture_on}, 32'd1);
        tick(1, 32'hA5A5_0001, 1);
        for (int i = 0; i < 4; i++) tick(1, 32'hDEAD_0000 + 32'(i), 0);
        repeat (2) tick(0, 0, 0);
        rd_reg(4'd6, v); chk("R5 count0 wptr", v, 32'd1);
        rd_reg(4'd3, v); chk("R5 R6 count0 status", v, exp_status());
        chk("R5 capture_on after done", {31'd0, capture_on}, 32'd0);
        readback_all("count0");

        // R3, R8: wrap, sticky across pointer write, cleared on restart
        restart_cap(100, 0);
        for (int i = 0; i < 20; i++) tick(1, 32'h1000 + 32'(i), 0);
        repeat (2) tick(0, 0, 0);
        rd_reg(4'd6, v); chk("R2 wptr wrap", v, 32'd4);
        rd_reg(4'd3, v); chk("R3 wrap set", v, exp_status());
        readback_all("wrap");
        wr_reg(4'd6, 0);
        rd_reg(4'd3, v); chk("R3 sticky after wptr write", v[0], 1'b1);
        tick(1, 32'hCAFE_F00D, 0);
        repeat (2) tick(0, 0, 0);
        wr_reg(4'd5, 0);
        rd_reg(4'd4, v); chk("R8 word at entry 0", v, 32'hCAFE_F00D);
        wr_reg(4'd8, 0); wr_reg(4'd8, 1);
        rd_reg(4'd3, v); chk("R3 cleared by restart", v, 32'd8);

        // randomized rounds
        for (int r = 0; r < 10; r++) begin
            int cnt, trig_at;
            cnt = int'($urandom % 6);
            trig_at = (r == 3) ? 99 : int'($urandom % 28);
            restart_cap(cnt, r[0]);
            for (int c = 0; c < 30; c++)
                tick(($urandom % 4) != 0, $urandom, c == trig_at);
            repeat (3) tick(0, 0, 0);
            rd_reg(4'd3, v); chk("R3 R4 R5 R6 round status", v, exp_status());
            rd_reg(4'd6, v); chk("R2 R5 round wptr", v, 32'(m_wp));
            rd_reg(4'd7, v); chk("R5 round count", v, 32'(m_cnt));
            chk("R9 round demux", {31'd0, demux_mode}, {31'd0, r[0]});
            readback_all("round");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule